// File: doc/BRIEF.md
# Serial Flash Status Register Guard

This block is the slave-side controller for the status register of a serial flash device. It sits behind a four-wire SPI port (active-low select, clock, data in, data out) and understands three commands. The first arms a write-enable latch. The second streams the status byte back to the host. The third replaces the protection fields of the register. SPI mode 0 is used: the block samples input on rising serial-clock edges and changes output on falling edges. All SPI pins are resynchronised into the block's own system clock domain, which must run several times faster than the serial clock.

An accepted status write starts a self-timed busy period that lasts a parameterised number of system clock cycles. During that period the host can keep reading the register and poll the busy flag. A sticky write-disable bit works together with an active-low write-protect pin. When the bit is set and the pin is held low, the register is locked against every status write.

The SPI data paths are bit-serial and have no back-pressure. The host owns the serial clock, and the block must keep pace with every edge. For this reason no valid/ready handshake exists here. All pins are plain control and data levels. The output enable tells the pad when the data-out line is driven; outside the read data phase the line must be treated as high impedance.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and the data-out enable is low.
- R2: Command 0x05 makes the block drive the status byte MSB first from the falling clock edge that follows the eighth command bit. The byte repeats for as long as select stays low. The output enable is high only in this data phase and falls within two system cycles after select rises.
- R3: Command 0x06 sets the write-enable latch (bit 1). This happens only when select rises after exactly eight clock bits; a frame with extra bits leaves the latch unchanged.
- R4: Command 0x01 followed by a data byte copies data bit 7 to write-disable (bit 7), data bit 3 to block-protect high (bit 3) and data bit 2 to block-protect low (bit 2). Bits 6, 5 and 4 always read 0, and bits 1 and 0 never take data values.
- R5: A status write commits only when select rises after exactly sixteen clock bits. With fifteen or seventeen bits, no field changes.
- R6: A status write issued while the write-enable latch is clear has no effect.
- R7: A committed write sets write-in-progress (bit 0) for WRITE_CYCLES system cycles and clears the write-enable latch at the start. Afterwards bit 0 reads 0.
- R8: While write-in-progress is 1 the status byte stays readable, and the write-enable and status-write commands are ignored.
- R9: When write-disable is 1 and the write-protect pin is low, a status write is ignored and the write-enable latch keeps its value. With the pin high, or with write-disable 0 at any pin level, the write goes ahead.
- R10: Any other command byte is ignored until select rises again, leaving the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High when spi_miso is driven |

## Verification
Status writes are sent with frames of fifteen, sixteen and seventeen bits, which separates commit on an exact byte boundary from early and late select release. The same write is repeated under four conditions: latch clear, busy, locked (write-disable set with the pin low), and unlocked (the pin high, or write-disable clear with the pin low). Each case has a distinct expected byte. Multi-byte reads show that the byte repeats. Reads taken straight after a commit and again after the busy period show the busy flag rising and falling. The write data uses all-ones and mixed patterns, which show that only bits 7, 3 and 2 take data.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

  localparam logic [7:0] CMD_WR_ENABLE = 8'h06;
  localparam logic [7:0] CMD_RD_STATUS = 8'h05;
  localparam logic [7:0] CMD_WR_STATUS = 8'h01;

  localparam int unsigned SR_LOCK = 7;
  localparam int unsigned SR_BPH  = 3;
  localparam int unsigned SR_BPL  = 2;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_BUSY = 0;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_WE_END,
    PH_READ,
    PH_WR_DATA,
    PH_WR_END,
    PH_DISCARD
  } frame_phase_e;

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic mosi_in,
  output logic cs_low,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] cs_pipe, sck_pipe, mosi_pipe;
  logic          cs_prev, sck_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_pipe[0]   <= 1'b1;
            sck_pipe[0]  <= 1'b0;
            mosi_pipe[0] <= 1'b0;
          end else begin
            cs_pipe[0]   <= cs_n_in;
            sck_pipe[0]  <= sck_in;
            mosi_pipe[0] <= mosi_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_pipe[g]   <= 1'b1;
            sck_pipe[g]  <= 1'b0;
            mosi_pipe[g] <= 1'b0;
          end else begin
            cs_pipe[g]   <= cs_pipe[g-1];
            sck_pipe[g]  <= sck_pipe[g-1];
            mosi_pipe[g] <= mosi_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_pipe[LAST];
      sck_prev <= sck_pipe[LAST];
    end
  end

  assign cs_low   = !cs_pipe[LAST];
  assign cs_rise  = cs_pipe[LAST] && !cs_prev;
  assign sck_rise = sck_pipe[LAST] && !sck_prev && cs_low;
  assign sck_fall = !sck_pipe[LAST] && sck_prev && cs_low;
  assign mosi_s   = mosi_pipe[LAST];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame
  import spi_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low,
  input  logic       cs_rise,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic [7:0] status_byte,
  output logic       we_req,
  output logic       wr_req,
  output logic [2:0] wr_fields,
  output logic       miso,
  output logic       miso_oe
);
  frame_phase_e phase;
  logic [2:0]   bit_cnt;
  logic [7:0]   in_sh;
  logic [7:0]   next_byte;
  logic         byte_done;
  logic [2:0]   out_cnt;
  logic [7:0]   out_sh;

  assign next_byte = {in_sh[6:0], mosi_s};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      in_sh     <= '0;
      wr_fields <= '0;
    end else if (!cs_low) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      in_sh   <= next_byte;
      unique case (phase)
        PH_CMD: begin
          if (byte_done) begin
            if (next_byte == CMD_WR_ENABLE)      phase <= PH_WE_END;
            else if (next_byte == CMD_RD_STATUS) phase <= PH_READ;
            else if (next_byte == CMD_WR_STATUS) phase <= PH_WR_DATA;
            else                                 phase <= PH_DISCARD;
          end
        end
        PH_WR_DATA: begin
          if (byte_done) begin
            wr_fields <= {next_byte[SR_LOCK], next_byte[SR_BPH], next_byte[SR_BPL]};
            phase     <= PH_WR_END;
          end
        end
        PH_WE_END, PH_WR_END: phase <= PH_DISCARD;
        default: phase <= phase;
      endcase
    end
  end

  assign we_req = cs_rise && (phase == PH_WE_END);
  assign wr_req = cs_rise && (phase == PH_WR_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      out_cnt <= '0;
      out_sh  <= '0;
    end else if (!cs_low) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      out_cnt <= '0;
    end else if (sck_fall && phase == PH_READ) begin
      miso_oe <= 1'b1;
      out_cnt <= out_cnt + 3'd1;
      if (out_cnt == 3'd0) begin
        miso   <= status_byte[7];
        out_sh <= {status_byte[6:0], 1'b0};
      end else begin
        miso   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_sr_status.sv
module spi_sr_status
  import spi_sr_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_req,
  input  logic       wr_req,
  input  logic [2:0] wr_fields,
  input  logic       wp_n,
  output logic [7:0] status_byte
);
  localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] CYC_LOAD = CW'(WRITE_CYCLES);

  logic          lock_bit;
  logic [1:0]    bp;
  logic          wel;
  logic [CW-1:0] busy_cnt;
  logic          busy;
  logic          hw_locked;
  logic          commit;

  assign busy      = (busy_cnt != '0);
  assign hw_locked = lock_bit && !wp_n;
  assign commit    = wr_req && wel && !busy && !hw_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bit <= 1'b0;
      bp       <= 2'b00;
      wel      <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (commit) begin
        lock_bit <= wr_fields[2];
        bp       <= wr_fields[1:0];
        wel      <= 1'b0;
        busy_cnt <= CYC_LOAD;
      end else begin
        if (we_req && !busy) wel <= 1'b1;
        if (busy) busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    status_byte          = '0;
    status_byte[SR_LOCK] = lock_bit;
    status_byte[SR_BPH]  = bp[1];
    status_byte[SR_BPL]  = bp[0];
    status_byte[SR_WEL]  = wel;
    status_byte[SR_BUSY] = busy;
  end
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import spi_sr_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 200,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic       cs_low, cs_rise, sck_rise, sck_fall, mosi_s;
  logic       we_req, wr_req;
  logic [2:0] wr_fields;
  logic [7:0] status_byte;
  logic       wel, wip, srwd;
  logic [1:0] bp;

  spi_sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_in(spi_cs_n), .sck_in(spi_sck), .mosi_in(spi_mosi),
    .cs_low(cs_low), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spi_sr_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_low(cs_low), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .status_byte(status_byte),
    .we_req(we_req), .wr_req(wr_req), .wr_fields(wr_fields),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_sr_status #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
    .clk(clk), .rst_n(rst_n),
    .we_req(we_req), .wr_req(wr_req), .wr_fields(wr_fields),
    .wp_n(wp_n),
    .status_byte(status_byte)
  );

  assign wel  = status_byte[SR_WEL];
  assign wip  = status_byte[SR_BUSY];
  assign srwd = status_byte[SR_LOCK];
  assign bp   = {status_byte[SR_BPH], status_byte[SR_BPL]};
endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_low,
  input logic       cs_rise,
  input logic       spi_miso_oe,
  input logic       wp_n,
  input logic       wel,
  input logic       wip,
  input logic       srwd,
  input logic [1:0] bp
);
  assert_oe_off_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> !spi_miso_oe);

  assert_latch_set_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  assert_fields_change_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(wip) |-> ($stable(srwd) && $stable(bp)));

  assert_commit_consumes_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(wel) && !wel));

  assert_busy_blocks_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !wel);

  assert_no_commit_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !($past(srwd) && !$past(wp_n)));
endmodule

bind spi_status_guard spi_status_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
  .spi_miso_oe(spi_miso_oe), .wp_n(wp_n), .wel(wel), .wip(wip),
  .srwd(srwd), .bp(bp)
);

// File: tb/test_spi_status_guard.sv
module test_spi_status_guard;
  localparam int unsigned WCYC = 600;
  localparam int unsigned HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_mosi = 1'b0;
  logic wp_n = 1'b1;
  logic spi_miso, spi_miso_oe;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  spi_status_guard #(.WRITE_CYCLES(WCYC)) i_spi_status_guard (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .wp_n(wp_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe)
  );

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = v[i];
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    cs_begin();
    send_bits(v, n);
    cs_end();
  endtask

  task automatic read_status(input int nbytes, input logic [7:0] exp, input string tag);
    cs_begin();
    send_bits(32'h05, 8);
    for (int b = 0; b < nbytes; b++) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    mon_en = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      send_bits(32'h00, 8);
      if (b == 0) check_val({7'd0, spi_miso_oe}, 8'h01, "R2 oe in data phase");
    end
    mon_en = 1'b0;
    cs_end();
    check_val({7'd0, spi_miso_oe}, 8'h00, "R2 oe after release");
  endtask

  // monitor: gathers read bytes and compares them with the scoreboard queue
  initial begin
    logic [7:0] rx;
    int n;
    rx = '0;
    n = 0;
    forever begin
      @(posedge spi_sck);
      if (mon_en) begin
        rx = {rx[6:0], spi_miso};
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2: unexpected byte actual %02h expected none", rx);
          end else begin
            check_val(rx, exp_q.pop_front(), tag_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check_val({7'd0, spi_miso_oe}, 8'h00, "R1 oe after reset");
    read_status(1, 8'h00, "R1 reset status");
    read_status(3, 8'h00, "R2 repeated byte");

    frame(32'h0C, 9);                     // write enable plus one extra bit
    read_status(1, 8'h00, "R3 extra bit keeps latch clear");
    frame(32'h06, 8);
    read_status(2, 8'h02, "R3 latch set");

    frame(32'hAB00, 16);                  // unknown command
    read_status(1, 8'h02, "R10 unknown command ignored");

    frame(32'h01FF >> 1, 15);             // status write one bit short
    read_status(1, 8'h02, "R5 fifteen bits no commit");
    frame({15'd0, 17'h01FF << 1}, 17);    // status write one bit long
    read_status(1, 8'h02, "R5 seventeen bits no commit");

    frame(32'h01FF, 16);                  // commit all-ones data
    read_status(1, 8'h8D, "R4 R7 busy after commit");
    frame(32'h06, 8);                     // ignored while busy
    read_status(1, 8'h8D, "R8 write enable ignored while busy");
    wait_clk(WCYC);
    read_status(1, 8'h8C, "R7 busy cleared");

    frame(32'h0100, 16);                  // latch clear
    read_status(1, 8'h8C, "R6 write without latch ignored");

    wp_n = 1'b0;
    frame(32'h06, 8);
    frame(32'h0100, 16);
    read_status(1, 8'h8E, "R9 locked write ignored");
    wp_n = 1'b1;
    frame(32'h0104, 16);
    read_status(1, 8'h05, "R9 pin high unlocks");
    frame(32'h0100, 16);                  // busy: must not commit
    wait_clk(WCYC);
    read_status(1, 8'h04, "R8 write during busy ignored");

    wp_n = 1'b0;
    frame(32'h06, 8);
    frame(32'h0188, 16);
    read_status(1, 8'h89, "R9 write-disable clear allows write");
    wait_clk(WCYC);
    read_status(1, 8'h88, "R7 R4 final value");

    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R2: actual %0d bytes missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule